// File: doc/BRIEF.md
# Range Access Violation Checker

This block watches a memory bus and judges every access against a small set of protected address windows. Each window is a naturally aligned block whose size is a power of two. Software sets its base and a size exponent. A privilege word grants read and write rights per window, and it also holds global rights for addresses that fall in no window. When an access is judged illegal, the block pulses a read-violation or write-violation event toward the interrupt logic. It also latches the offending address for software to inspect.

Configuration goes through a simple word-indexed register port. The register port exposes one register per window, the privilege word, a self-test register and the captured violation address. When self-test is armed, a software write to the self-test register is judged as a write access to the address carried in its data. This lets the detection path be exercised without a real bad bus access. The block only observes: it never stalls or aborts the bus.

Top module: `mem_guard`

## Requirements
- R1: After reset every register reads zero, the checker is off and both event outputs are low.
- R2: Register index 0 to 5 is a window register: bits 31:9 hold the base and bits 4:0 hold the size exponent `k`. An address lies in the window when its bits 31:`k` equal the base bits 31:`k`. The window is live only for `k` from 9 to 21, that is 512 bytes to 2 MB. Any other `k` means the window never contains an address.
- R3: Privilege word (index 6): bits 5:0 grant write to windows 0..5 and bits 15:10 grant read to windows 0..5. An access that lands in one or more windows is legal exactly when at least one of those windows grants its direction. The global rights play no part in that case.
- R4: An access in no window is legal when the global right for its direction is set: privilege bit 9 for writes and bit 19 for reads.
- R5: With privilege bit 31 (checker on) clear, no access raises an event.
- R6: An illegal access raises `rd_viol` (read) or `wr_viol` (write) for exactly one cycle, in the cycle after the access is presented. Both are never high together.
- R7: The first illegal address is latched in the violation register (index 8). Later violations still pulse their events but leave the latched value alone until software reads or writes index 8. A violation in that same release cycle is latched.
- R8: With privilege bit 30 (self-test) set, a write to index 7 is judged as a write access to the address in `cfg_wdata`. With bit 30 clear, the write has no effect on the events. When a bus access is presented in the same cycle, the bus access is judged and the self-test write is not.
- R9: Readback keeps only the defined bits. A window register reads back bits 31:9 and 4:0. The privilege word reads back bits 31, 30, 19, 15:10, 9 and 5:0. The self-test register reads back all 32 bits. Unused indices read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | A bus access is presented this cycle |
| acc_addr | input | 32 | Byte address of the bus access |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (releases the violation latch at index 8) |
| cfg_idx | input | 4 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_idx` |
| rd_viol | output | 1 | One-cycle read-violation event |
| wr_viol | output | 1 | One-cycle write-violation event |

## Verification
The bench goes after overlapping windows where only one window grants the right. A design that let the global right override a window hit would pass such an access when it should flag it. Addresses one byte past a window's end and a window with an out-of-range size exponent are probed: a wrong mask width or a missing exponent check makes the design claim a hit that is not there. The bench fires a second violation while the first is still latched and then again after a readback. A latch that overwrote or never released would report the wrong address. Self-test writes are sent with self-test off and alongside a bus access, where a design that judged them anyway would raise spurious write events.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam int ADDR_W   = 32;
  localparam int IDX_W    = 4;
  localparam int CODE_W   = 5;
  localparam int BASE_LSB = 9;
  localparam int CODE_MIN = 9;
  localparam int CODE_MAX = 21;

  // privilege word bit positions (decoded by software, so fixed)
  localparam int PB_WR_LSB = 0;
  localparam int PB_GLB_WR = 9;
  localparam int PB_RD_LSB = 10;
  localparam int PB_GLB_RD = 19;
  localparam int PB_TEST   = 30;
  localparam int PB_ON     = 31;

  localparam logic [IDX_W-1:0] IDX_PRIV = 4'd6;
  localparam logic [IDX_W-1:0] IDX_TEST = 4'd7;
  localparam logic [IDX_W-1:0] IDX_VIOL = 4'd8;

  localparam logic [ADDR_W-1:0] BASE_MASK = {{(ADDR_W-BASE_LSB){1'b1}}, {BASE_LSB{1'b0}}};

  function automatic logic size_code_ok(input logic [CODE_W-1:0] code);
    return (int'(code) >= CODE_MIN) && (int'(code) <= CODE_MAX);
  endfunction

  // ones above the window offset, zeros inside it
  function automatic logic [ADDR_W-1:0] span_mask(input logic [CODE_W-1:0] code);
    return ~((ADDR_W'(1) << code) - ADDR_W'(1));
  endfunction

  function automatic logic addr_in_window(input logic [ADDR_W-1:0] addr,
                                         input logic [ADDR_W-1:0] base,
                                         input logic [CODE_W-1:0] code);
    logic [ADDR_W-1:0] m;
    m = span_mask(code);
    return size_code_ok(code) && ((addr & m) == (base & m));
  endfunction
endpackage

// File: rtl/mg_range_match.sv
module mg_range_match
  import mg_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0]     addr,
  input  logic [AW-1:0]     base,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  always_comb begin
    hit = addr_in_window(addr, base, code);
  end
endmodule

// File: rtl/mg_judge.sv
module mg_judge #(
  parameter int NRANGE = 6
) (
  input  logic [NRANGE-1:0] hit,
  input  logic [NRANGE-1:0] rd_perm,
  input  logic [NRANGE-1:0] wr_perm,
  input  logic              glb_rd,
  input  logic              glb_wr,
  input  logic              chk_on,
  input  logic              check,
  input  logic              is_write,
  output logic              violate
);
  logic [NRANGE-1:0] need;
  logic              any_hit;
  logic              granted;
  logic              fallback;

  always_comb begin
    need     = is_write ? wr_perm : rd_perm;
    any_hit  = |hit;
    granted  = |(hit & need);
    fallback = is_write ? glb_wr : glb_rd;
    violate  = check && chk_on && (any_hit ? !granted : !fallback);
  end
endmodule

// File: rtl/mg_viol_capture.sv
module mg_viol_capture #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          violate,
  input  logic          is_write,
  input  logic [AW-1:0] chk_addr,
  input  logic          release_i,
  output logic          rd_evt,
  output logic          wr_evt,
  output logic [AW-1:0] viol_addr
);
  logic held;
  logic take;

  always_comb begin
    take = violate && (!held || release_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_evt    <= 1'b0;
      wr_evt    <= 1'b0;
      held      <= 1'b0;
      viol_addr <= '0;
    end else begin
      rd_evt <= violate && !is_write;
      wr_evt <= violate && is_write;
      if (take) begin
        viol_addr <= chk_addr;
        held      <= 1'b1;
      end else if (release_i) begin
        held <= 1'b0;
      end
    end
  end

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_evt, wr_evt})); // R6
  AST_EVT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    violate |=> (rd_evt || wr_evt)); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !release_i) |=> $stable(viol_addr)); // R7
  AST_FIRST_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (viol_addr == $past(chk_addr))); // R7
endmodule

// File: rtl/mg_cfg_regs.sv
module mg_cfg_regs
  import mg_pkg::*;
#(
  parameter int NRANGE = 6,
  parameter int AW     = ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [AW-1:0]     cfg_rdata,
  input  logic [AW-1:0]     viol_addr,
  output logic [AW-1:0]     rng_base [NRANGE],
  output logic [CODE_W-1:0] rng_code [NRANGE],
  output logic [NRANGE-1:0] rd_perm,
  output logic [NRANGE-1:0] wr_perm,
  output logic              glb_rd,
  output logic              glb_wr,
  output logic              chk_on,
  output logic              test_mode,
  output logic              test_fire,
  output logic              viol_release
);
  logic [AW-1:0] test_q;
  logic [AW-1:0] priv_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NRANGE; i++) begin
        rng_base[i] <= '0;
        rng_code[i] <= '0;
      end
    end else if (cfg_wr) begin
      for (int i = 0; i < NRANGE; i++) begin
        if (cfg_idx == IDX_W'(i)) begin
          rng_base[i] <= cfg_wdata & BASE_MASK;
          rng_code[i] <= cfg_wdata[CODE_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_perm   <= '0;
      wr_perm   <= '0;
      glb_rd    <= 1'b0;
      glb_wr    <= 1'b0;
      chk_on    <= 1'b0;
      test_mode <= 1'b0;
    end else if (cfg_wr && cfg_idx == IDX_PRIV) begin
      wr_perm   <= cfg_wdata[PB_WR_LSB +: NRANGE];
      rd_perm   <= cfg_wdata[PB_RD_LSB +: NRANGE];
      glb_wr    <= cfg_wdata[PB_GLB_WR];
      glb_rd    <= cfg_wdata[PB_GLB_RD];
      test_mode <= cfg_wdata[PB_TEST];
      chk_on    <= cfg_wdata[PB_ON];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_q <= '0;
    end else if (cfg_wr && cfg_idx == IDX_TEST) begin
      test_q <= cfg_wdata;
    end
  end

  always_comb begin
    test_fire    = cfg_wr && (cfg_idx == IDX_TEST) && test_mode;
    viol_release = (cfg_wr || cfg_rd) && (cfg_idx == IDX_VIOL);
  end

  always_comb begin
    priv_word                           = '0;
    priv_word[PB_WR_LSB +: NRANGE]      = wr_perm;
    priv_word[PB_RD_LSB +: NRANGE]      = rd_perm;
    priv_word[PB_GLB_WR]                = glb_wr;
    priv_word[PB_GLB_RD]                = glb_rd;
    priv_word[PB_TEST]                  = test_mode;
    priv_word[PB_ON]                    = chk_on;
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NRANGE; i++) begin
      if (cfg_idx == IDX_W'(i)) cfg_rdata = rng_base[i] | AW'(rng_code[i]);
    end
    case (cfg_idx)
      IDX_PRIV: cfg_rdata = priv_word;
      IDX_TEST: cfg_rdata = test_q;
      IDX_VIOL: cfg_rdata = viol_addr;
      default:  ;
    endcase
  end
endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mg_pkg::*;
#(
  parameter int NRANGE = 6,
  parameter int AW     = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [AW-1:0]    acc_addr,
  input  logic             acc_write,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [AW-1:0]    cfg_wdata,
  output logic [AW-1:0]    cfg_rdata,
  output logic             rd_viol,
  output logic             wr_viol
);
  logic [AW-1:0]     rng_base [NRANGE];
  logic [CODE_W-1:0] rng_code [NRANGE];
  logic [NRANGE-1:0] rd_perm;
  logic [NRANGE-1:0] wr_perm;
  logic              glb_rd;
  logic              glb_wr;
  logic              chk_on;
  logic              test_mode;
  logic              test_fire;
  logic              viol_release;
  logic [AW-1:0]     viol_addr;

  // judged access: the bus wins over a self-test write
  logic              check;
  logic [AW-1:0]     chk_addr;
  logic              chk_write;
  logic [NRANGE-1:0] hit;
  logic              violate;

  mg_cfg_regs #(.NRANGE(NRANGE), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .viol_addr(viol_addr), .rng_base(rng_base), .rng_code(rng_code),
    .rd_perm(rd_perm), .wr_perm(wr_perm), .glb_rd(glb_rd), .glb_wr(glb_wr),
    .chk_on(chk_on), .test_mode(test_mode), .test_fire(test_fire),
    .viol_release(viol_release)
  );

  always_comb begin
    check     = acc_valid || test_fire;
    chk_addr  = acc_valid ? acc_addr : cfg_wdata;
    chk_write = acc_valid ? acc_write : 1'b1;
  end

  for (genvar g = 0; g < NRANGE; g++) begin : g_win
    mg_range_match #(.AW(AW)) u_match (
      .addr(chk_addr), .base(rng_base[g]), .code(rng_code[g]), .hit(hit[g])
    );
  end

  mg_judge #(.NRANGE(NRANGE)) u_judge (
    .hit(hit), .rd_perm(rd_perm), .wr_perm(wr_perm), .glb_rd(glb_rd),
    .glb_wr(glb_wr), .chk_on(chk_on), .check(check), .is_write(chk_write),
    .violate(violate)
  );

  mg_viol_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_n), .violate(violate), .is_write(chk_write),
    .chk_addr(chk_addr), .release_i(viol_release), .rd_evt(rd_viol),
    .wr_evt(wr_viol), .viol_addr(viol_addr)
  );

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (check && !chk_on) |=> (!rd_viol && !wr_viol)); // R5
  AST_TEST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !test_mode) |=> (!rd_viol && !wr_viol)); // R8
endmodule

// File: tb/mem_guard_tb_top.sv
module mem_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        rd_viol;
  logic        wr_viol;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  bit    cmp_on = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  mem_guard dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rd_viol(rd_viol), .wr_viol(wr_viol)
  );

  // ---------------- reference model ----------------
  bit [31:0] m_rng [6];
  bit [31:0] m_priv, m_test, m_va;
  bit        m_held, exp_rv, exp_wv;

  function automatic bit m_allowed(bit [31:0] a, bit w);
    bit any = 0, ok = 0;
    if (!m_priv[31]) return 1'b1;
    for (int i = 0; i < 6; i++) begin
      int c = int'(m_rng[i][4:0]);
      if (c >= 9 && c <= 21 && (a >> c) == (m_rng[i] >> c)) begin
        any = 1;
        if (w ? m_priv[i] : m_priv[10+i]) ok = 1;
      end
    end
    if (any) return ok;
    return w ? m_priv[9] : m_priv[19];
  endfunction

  function automatic bit [31:0] m_read(int idx);
    if (idx < 6) return m_rng[idx];
    if (idx == 6) return m_priv;
    if (idx == 7) return m_test;
    if (idx == 8) return m_va;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_rng[i]) m_rng[i] = 0;
      m_priv = 0; m_test = 0; m_va = 0; m_held = 0; exp_rv = 0; exp_wv = 0;
    end else begin
      bit inj, chk, w, v, rel;
      bit [31:0] a;
      inj = cfg_wr && cfg_idx == 7 && m_priv[30] && !acc_valid;
      chk = acc_valid || inj;
      a   = acc_valid ? acc_addr : cfg_wdata;
      w   = acc_valid ? acc_write : 1'b1;
      v   = chk && !m_allowed(a, w);
      exp_rv = v && !w;
      exp_wv = v && w;
      rel = (cfg_rd || cfg_wr) && cfg_idx == 8;
      if (v && (!m_held || rel)) begin m_va = a; m_held = 1; end
      else if (rel) m_held = 0;
      if (cfg_wr) begin
        if (cfg_idx < 6) m_rng[cfg_idx] = cfg_wdata & 32'hFFFF_FE1F;
        else if (cfg_idx == 6) m_priv = cfg_wdata & 32'hC008_FE3F;
        else if (cfg_idx == 7) m_test = cfg_wdata;
      end
    end
  end

  // event comparison on every clock (R6 timing)
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (rd_viol !== exp_rv || wr_viol !== exp_wv) begin
        errors++;
        $display("FAIL %s events rd/wr actual %b%b expected %b%b at %0t",
                 cur_tag, rd_viol, wr_viol, exp_rv, exp_wv, $time);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic acc(input bit [31:0] a, input bit w);
    @(negedge clk); acc_valid = 1; acc_addr = a; acc_write = w;
    @(negedge clk); acc_valid = 0;
  endtask

  task automatic wreg(input int idx, input bit [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_idx = 4'(idx); cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic both(input bit [31:0] a, input bit w, input int idx, input bit [31:0] d);
    @(negedge clk); acc_valid = 1; acc_addr = a; acc_write = w;
    cfg_wr = 1; cfg_idx = 4'(idx); cfg_wdata = d;
    @(negedge clk); acc_valid = 0; cfg_wr = 0;
  endtask

  task automatic rchk(input int idx, input bit [31:0] fixed_exp, input bit use_fixed);
    bit [31:0] e;
    @(negedge clk); cfg_rd = 1; cfg_idx = 4'(idx);
    #1;
    e = use_fixed ? fixed_exp : m_read(idx);
    checks++;
    if (cfg_rdata !== e) begin
      errors++;
      $display("FAIL %s read idx %0d actual %h expected %h", cur_tag, idx, cfg_rdata, e);
    end
    @(negedge clk); cfg_rd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp_on = 1;
    rst_n = 1;
    // R1: reset state
    cur_tag = "R1";
    for (int i = 0; i < 9; i++) rchk(i, 32'h0, 1);
    // R9: readback keeps only defined bits
    cur_tag = "R9";
    wreg(0, 32'hFFFF_FFFF); rchk(0, 32'hFFFF_FE1F, 1);
    wreg(6, 32'hFFFF_FFFF); rchk(6, 32'hC008_FE3F, 1);
    wreg(7, 32'h0000_1234); rchk(7, 32'h0000_1234, 1);
    rchk(12, 32'h0, 1);
    // R2/R3/R4 window setup
    cur_tag = "R2";
    wreg(0, 32'h0001_000C);   // 4 KB at 0x10000
    wreg(1, 32'h0002_0009);   // 512 B at 0x20000
    wreg(2, 32'h0001_080B);   // 2 KB at 0x10800, inside window 0
    wreg(3, 32'h0040_0016);   // exponent 22: never matches
    wreg(4, 32'h0);
    wreg(5, 32'h0);
    wreg(6, 32'h8000_1801);   // on, w0, r1, r2
    rchk(8, 32'h0, 1);        // release latch left from R9 stage
    acc(32'h0001_0004, 1);    // R2: write in window 0, allowed
    cur_tag = "R3";
    acc(32'h0001_0004, 0);    // read, window 0 lacks read: violation
    acc(32'h0001_0900, 0);    // overlap, window 2 grants read
    acc(32'h0001_0900, 1);    // overlap, window 0 grants write
    cur_tag = "R7";
    acc(32'h0002_0100, 1);    // window 1 lacks write: second violation
    rchk(8, 32'h0001_0004, 1); // first one kept
    cur_tag = "R2";
    acc(32'h0002_01FF, 0);    // last byte of window 1, allowed
    acc(32'h0002_0200, 0);    // one past the end: no window, no global
    acc(32'h0040_0000, 0);    // bad exponent: no window
    cur_tag = "R7";
    rchk(8, 32'h0002_0200, 1);
    cur_tag = "R4";
    wreg(6, 32'h8008_1801);   // add global read
    acc(32'h0040_0000, 0);    // no window: global read allows
    acc(32'h0040_0000, 1);    // no window: global write missing
    cur_tag = "R3";
    wreg(6, 32'h8008_1A01);   // global write + global read
    acc(32'h0001_0004, 0);    // hit without right: globals ignored
    acc(32'h0002_0010, 1);    // hit without write
    cur_tag = "R7";
    rchk(8, 32'h0040_0000, 1);
    // R5: checker off
    cur_tag = "R5";
    wreg(6, 32'h0000_0000);
    acc(32'h0001_0004, 0);
    acc(32'h0040_0000, 1);
    rchk(8, 32'h0, 0);
    // R8: self-test
    cur_tag = "R8";
    wreg(6, 32'h0008_0000);          // self-test off, checker off
    wreg(7, 32'h0001_0004);          // no event
    wreg(6, 32'h8008_0000);          // on, global read, test off
    wreg(7, 32'h0001_0004);          // still ignored
    wreg(6, 32'hC008_0000);          // on + self-test
    wreg(7, 32'h0001_0004);          // judged as write: violation
    both(32'h0050_0000, 0, 7, 32'h0001_0008); // bus read allowed; test write dropped
    rchk(7, 32'h0001_0008, 1);
    rchk(8, 32'h0, 0);
    // R6: back-to-back events of both kinds
    cur_tag = "R6";
    wreg(6, 32'h8000_0000);
    @(negedge clk); acc_valid = 1; acc_addr = 32'h100; acc_write = 1;
    @(negedge clk); acc_write = 0;
    @(negedge clk); acc_valid = 0;
    wreg(8, 32'h0);
    rchk(8, 32'h0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule